// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns raw external interrupt pins into pending request flags for an interrupt controller. It serves four pin groups: one non-maskable pin, sixteen general request pins, sixteen key-input pins and eight wake-up pins. Every pin is first passed through a synchronizer. Each pin then goes through a detector that applies that pin's sense setting and keeps a pending flag. The flag is dropped by a per-flag clear strobe.

A single vector-mode input decides how the key inputs are used. In compatible mode (0), the keys are wired into two of the general requests, so any low key in a group of eight pulls that request's source low. In extended mode (1), each key raises a request flag of its own on a falling edge. Priority arbitration and the mapping of pins to ports are handled outside this block.

Top module: `extint_detect`

## Requirements
- R1: After reset, with every pin held high, all pending flags read 0.
- R2: The non-maskable pin detects a falling edge when `nmi_rise`=0 and a rising edge when `nmi_rise`=1. A detected edge shows on `nmi_pend` three clock edges after the pin changes.
- R3: The field `irq_sense[2i+1:2i]` selects the sense for general pin i. The codes are 00 for a falling edge, 01 for a rising edge and 10 for both edges. An edge of the opposite direction is ignored.
- R4: The code 11 selects low-level sensing. In this mode the flag follows the pin with three cycles of latency, and a clear strobe has no effect while the pin stays low.
- R5: An edge-sensed flag stays set until its clear strobe arrives. If a new edge is detected in the same cycle as the clear strobe, the flag stays set.
- R6: When `ext_vec`=0, the source of request 6 is general pin 6 ANDed with key inputs 7..0. The source of request 7 is general pin 7 ANDed with key inputs 15..8. A key going low therefore raises the merged request under that request's sense setting, and `key_pend` stays all zero.
- R7: When `ext_vec`=1, each key input k sets `key_pend[k]` on a falling edge, and requests 6 and 7 follow only their own general pins.
- R8: Wake-up pin j detects a rising edge when `wake_rise[j]`=1 and a falling edge when it is 0. This does not depend on `ext_vec`.
- R9: When a pin's sense setting changes, no edge is detected in the first cycle the new setting is seen. The previous-sample register is still reloaded in that cycle, so the edge is not reported later either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable pin |
| nmi_rise | input | 1 | Non-maskable edge select (1 = rising) |
| irq_pin | input | 16 | General request pins |
| irq_sense | input | 32 | Two-bit sense code per general pin |
| key_pin | input | 16 | Key-input pins |
| ext_vec | input | 1 | Vector mode: 0 merged, 1 independent |
| wake_pin | input | 8 | Wake-up pins |
| wake_rise | input | 8 | Wake-up edge select per pin (1 = rising) |
| clr_nmi | input | 1 | Clear strobe for the non-maskable flag |
| clr_irq | input | 16 | Clear strobes for general flags |
| clr_key | input | 16 | Clear strobes for key flags |
| clr_wake | input | 8 | Clear strobes for wake-up flags |
| nmi_pend | output | 1 | Non-maskable pending flag |
| irq_pend | output | 16 | General request pending flags |
| key_pend | output | 16 | Key-input pending flags (extended mode) |
| wake_pend | output | 8 | Wake-up pending flags |

## Verification
Some properties are checked on every cycle. A low level-sensed pin must raise its flag on the next cycle, and a disabled key detector must keep its flag low. A set edge flag must hold while no clear strobe arrives, and a clear strobe that meets no new edge must drop the flag. Other behaviour can only be shown by the bench's scenarios: the direction selected by each sense code, the three-cycle latency, the AND-merge of the key groups in compatible mode, clear-versus-set ordering, and suppressing an edge that coincides with a change of sense setting.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      SENSE_FALL  = 2'b00,
      SENSE_RISE  = 2'b01,
      SENSE_BOTH  = 2'b10,
      SENSE_LEVEL = 2'b11
   } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic       RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/extint_pend.sv
module extint_pend
   import extint_pkg::*;
#(
   parameter logic IDLE = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   smp,
   input  sense_e sense,
   input  logic   en,
   input  logic   mode,
   input  logic   clr,
   output logic   pend
);
   logic       prev;
   logic [3:0] cfg_q;
   logic       chg, fall, rise, hit, take;

   assign chg  = ({en, mode, sense} != cfg_q);
   assign fall = prev & ~smp;
   assign rise = ~prev & smp;

   always_comb begin
      unique case (sense)
         SENSE_FALL: hit = fall;
         SENSE_RISE: hit = rise;
         SENSE_BOTH: hit = fall | rise;
         default:    hit = 1'b0;
      endcase
   end

   assign take = hit & ~chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= IDLE;
         cfg_q <= '0;
         pend  <= 1'b0;
      end else begin
         prev  <= smp;
         cfg_q <= {en, mode, sense};
         if (!en)                       pend <= 1'b0;
         else if (sense == SENSE_LEVEL) pend <= ~smp;
         else if (take)                 pend <= 1'b1;
         else if (clr)                  pend <= 1'b0;
      end
   end

   // R4: a low level-sensed source raises the flag next cycle
   p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sense == SENSE_LEVEL && !smp) |=> pend);
   // R5: edge flag holds without clear
   p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sense != SENSE_LEVEL && pend && !clr) |=> pend);
   // R5: clear with no coincident edge drops the flag
   p_edge_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sense != SENSE_LEVEL && clr && !take) |=> !pend);
   // R7: disabled detector keeps its flag low
   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pend);
endmodule

// File: rtl/extint_detect.sv
module extint_detect
   import extint_pkg::*;
#(
   parameter int N_IRQ    = 16,
   parameter int N_KEY    = 16,
   parameter int N_WAKE   = 8,
   parameter int STAGES   = 2,
   parameter int MERGE_LO = 6,
   parameter int MERGE_HI = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                nmi_pin,
   input  logic                nmi_rise,
   input  logic [N_IRQ-1:0]    irq_pin,
   input  logic [2*N_IRQ-1:0]  irq_sense,
   input  logic [N_KEY-1:0]    key_pin,
   input  logic                ext_vec,
   input  logic [N_WAKE-1:0]   wake_pin,
   input  logic [N_WAKE-1:0]   wake_rise,
   input  logic                clr_nmi,
   input  logic [N_IRQ-1:0]    clr_irq,
   input  logic [N_KEY-1:0]    clr_key,
   input  logic [N_WAKE-1:0]   clr_wake,
   output logic                nmi_pend,
   output logic [N_IRQ-1:0]    irq_pend,
   output logic [N_KEY-1:0]    key_pend,
   output logic [N_WAKE-1:0]   wake_pend
);
   localparam int KH = N_KEY / 2;

   if ((N_KEY % 2) != 0 || N_KEY < 2) begin : g_bad_key
      $error("extint_detect: N_KEY must be even and nonzero");
   end
   if (MERGE_LO >= N_IRQ || MERGE_HI >= N_IRQ || MERGE_LO == MERGE_HI) begin : g_bad_merge
      $error("extint_detect: merge indices out of range");
   end

   logic              nmi_s;
   logic [N_IRQ-1:0]  irq_s, irq_src;
   logic [N_KEY-1:0]  key_s;
   logic [N_WAKE-1:0] wake_s;

   extint_sync #(.W(1),      .STAGES(STAGES)) u_sync_nmi  (.clk, .rst_n, .d(nmi_pin),  .q(nmi_s));
   extint_sync #(.W(N_IRQ),  .STAGES(STAGES)) u_sync_irq  (.clk, .rst_n, .d(irq_pin),  .q(irq_s));
   extint_sync #(.W(N_KEY),  .STAGES(STAGES)) u_sync_key  (.clk, .rst_n, .d(key_pin),  .q(key_s));
   extint_sync #(.W(N_WAKE), .STAGES(STAGES)) u_sync_wake (.clk, .rst_n, .d(wake_pin), .q(wake_s));

   always_comb begin
      irq_src = irq_s;
      if (!ext_vec) begin
         irq_src[MERGE_LO] = irq_s[MERGE_LO] & (&key_s[KH-1:0]);
         irq_src[MERGE_HI] = irq_s[MERGE_HI] & (&key_s[N_KEY-1:KH]);
      end
   end

   extint_pend u_nmi (
      .clk, .rst_n, .smp(nmi_s),
      .sense(nmi_rise ? SENSE_RISE : SENSE_FALL),
      .en(1'b1), .mode(1'b0), .clr(clr_nmi), .pend(nmi_pend));

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      localparam bit MERGED = (i == MERGE_LO) || (i == MERGE_HI);
      extint_pend u_pend (
         .clk, .rst_n, .smp(irq_src[i]),
         .sense(sense_e'(irq_sense[2*i +: 2])),
         .en(1'b1), .mode(MERGED ? ext_vec : 1'b0),
         .clr(clr_irq[i]), .pend(irq_pend[i]));
   end

   for (genvar k = 0; k < N_KEY; k++) begin : g_key
      extint_pend u_pend (
         .clk, .rst_n, .smp(key_s[k]), .sense(SENSE_FALL),
         .en(ext_vec), .mode(1'b0),
         .clr(clr_key[k]), .pend(key_pend[k]));
   end

   for (genvar j = 0; j < N_WAKE; j++) begin : g_wake
      extint_pend u_pend (
         .clk, .rst_n, .smp(wake_s[j]),
         .sense(wake_rise[j] ? SENSE_RISE : SENSE_FALL),
         .en(1'b1), .mode(1'b0),
         .clr(clr_wake[j]), .pend(wake_pend[j]));
   end

   // R6: in merged mode no key flag is ever raised
   p_key_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_vec |=> (key_pend == '0));
endmodule

// File: tb/test_extint_detect.sv
`timescale 1ns/1ps
module test_extint_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_pin = 1'b1, nmi_rise = 1'b0;
   logic [15:0] irq_pin = '1;
   logic [31:0] irq_sense = '0;
   logic [15:0] key_pin = '1;
   logic        ext_vec = 1'b0;
   logic [7:0]  wake_pin = '1, wake_rise = '0;
   logic        clr_nmi = 1'b0;
   logic [15:0] clr_irq = '0, clr_key = '0;
   logic [7:0]  clr_wake = '0;
   logic        nmi_pend;
   logic [15:0] irq_pend, key_pend;
   logic [7:0]  wake_pend;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   extint_detect i_extint_detect (.*);

   // idx[8:5] sense[4:3] start[2] fin[1] exp[0]
   localparam logic [8:0] VECS [0:8] = '{
      {4'd0,  2'b00, 1'b1, 1'b0, 1'b1},
      {4'd1,  2'b00, 1'b0, 1'b1, 1'b0},
      {4'd2,  2'b01, 1'b0, 1'b1, 1'b1},
      {4'd3,  2'b01, 1'b1, 1'b0, 1'b0},
      {4'd4,  2'b10, 1'b1, 1'b0, 1'b1},
      {4'd5,  2'b10, 1'b0, 1'b1, 1'b1},
      {4'd8,  2'b11, 1'b1, 1'b0, 1'b1},
      {4'd9,  2'b11, 1'b0, 1'b1, 1'b0},
      {4'd15, 2'b00, 1'b1, 1'b0, 1'b1}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      clr_nmi = 1'b1; clr_irq = '1; clr_key = '1; clr_wake = '1;
      tick(1);
      clr_nmi = 1'b0; clr_irq = '0; clr_key = '0; clr_wake = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(4);
      // R1
      check("R1", {nmi_pend, irq_pend, key_pend[7:0], wake_pend}, '0);
      check("R1 keys", key_pend, '0);

      // R3 / R4: vector table over general pins
      for (int v = 0; v < 9; v++) begin
         automatic int idx = VECS[v][8:5];
         irq_sense[2*idx +: 2] = VECS[v][4:3];
         irq_pin[idx] = VECS[v][2];
         tick(5);
         clear_all();
         tick(1);
         irq_pin[idx] = VECS[v][1];
         tick(4);
         check(VECS[v][4:3] == 2'b11 ? "R4 table" : "R3 table",
               irq_pend[idx], VECS[v][0]);
         irq_pin[idx] = 1'b1;
         tick(5);
         irq_sense[2*idx +: 2] = 2'b00;
         tick(2);
         clear_all();
         tick(1);
      end

      // R4: clear ineffective while level low
      irq_sense[21:20] = 2'b11;
      irq_pin[10] = 1'b0;
      tick(5);
      clear_all();
      tick(1);
      check("R4 clear held", irq_pend[10], 1'b1);
      irq_pin[10] = 1'b1;
      tick(2);
      check("R4 latency still set", irq_pend[10], 1'b1);
      tick(1);
      check("R4 drops", irq_pend[10], 1'b0);
      irq_sense[21:20] = 2'b00;
      tick(3);

      // R2: non-maskable falling, hold, clear, then rising
      nmi_pin = 1'b0;
      tick(2);
      check("R2 before latency", nmi_pend, 1'b0);
      tick(1);
      check("R2 falling", nmi_pend, 1'b1);
      tick(5);
      check("R5 hold", nmi_pend, 1'b1);
      clear_all();
      check("R5 cleared", nmi_pend, 1'b0);
      nmi_rise = 1'b1;
      tick(2);
      nmi_pin = 1'b1;
      tick(4);
      check("R2 rising", nmi_pend, 1'b1);
      clear_all();

      // R5: clear coincident with new edge
      irq_sense[23:22] = 2'b10;
      tick(3);
      irq_pin[11] = 1'b0;
      tick(2);
      clr_irq[11] = 1'b1;
      tick(1);
      clr_irq[11] = 1'b0;
      check("R5 set wins", irq_pend[11], 1'b1);

      // R9: sense change coincident with edge suppresses it
      irq_sense[25:24] = 2'b01;
      tick(3);
      clear_all();
      irq_pin[12] = 1'b0;
      tick(3);
      irq_pin[12] = 1'b1;
      tick(2);
      irq_sense[25:24] = 2'b10;
      tick(4);
      check("R9 suppressed", irq_pend[12], 1'b0);

      // R6: merged mode
      ext_vec = 1'b0;
      irq_sense = '0;
      tick(3);
      clear_all();
      key_pin[10] = 1'b0;
      tick(4);
      check("R6 req7 from key", irq_pend[7], 1'b1);
      check("R6 req6 quiet", irq_pend[6], 1'b0);
      check("R6 key flags", key_pend, '0);
      key_pin[10] = 1'b1;
      key_pin[2] = 1'b0;
      tick(4);
      check("R6 req6 from key", irq_pend[6], 1'b1);
      key_pin[2] = 1'b1;
      tick(4);

      // R7: extended mode
      ext_vec = 1'b1;
      tick(3);
      clear_all();
      key_pin[3] = 1'b0;
      tick(4);
      check("R7 key flag", key_pend, 16'h0008);
      check("R7 req6 independent", irq_pend[6], 1'b0);
      key_pin[3] = 1'b1;
      tick(4);
      check("R7 rise ignored", key_pend, 16'h0008);

      // R8: wake-up pins, per-pin direction
      wake_rise[2] = 1'b1;
      wake_pin[2] = 1'b0;
      wake_pin[5] = 1'b0;
      tick(4);
      check("R8 rise-select ignores fall", wake_pend[2], 1'b0);
      check("R8 falling", wake_pend[5], 1'b1);
      clear_all();
      wake_pin[2] = 1'b1;
      tick(4);
      check("R8 rising", wake_pend, 8'h04);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule